// File: doc/BRIEF.md
# Byte-Lane Data Memory Slave

This block is the data memory behind a 32-bit processor's load/store port. The core presents an address, a four-bit lane-select pattern, a write flag, an access enable and write data. The memory works out the access size from the lane pattern and checks that the address is aligned for that size. Storage is byte-addressed and big-endian. Write data is right-aligned, and a read always returns the whole containing word.

Each accepted access drops the ready output for two cycles, which stalls the core. Enables that arrive while ready is low are ignored. One fixed address is not storage: it is a byte-wide console output. A byte write there produces a one-cycle strobe together with the written byte. Any illegal access sets a sticky error flag, leaves storage untouched and returns zero read data.

Top module: `lane_mem_slave`

## Requirements
- R1: A synchronous active-high reset sets ready high, clears the error flag and the console strobe, and drives read data to zero. It leaves the stored bytes unchanged.
- R2: The lane patterns 1000, 0100, 0010 and 0001 (binary, bit 3 first) each mean a single-byte access, which is legal at any address.
- R3: The lane patterns 1100 and 0011 mean a halfword access, which is legal only when address bit 0 is zero.
- R4: The lane pattern 1111 means a word access, which is legal only when address bits 1:0 are both zero.
- R5: Any other lane pattern is illegal, and so is a misaligned halfword or word. An illegal access sets the error flag, which stays set until reset. Storage is not modified, and an illegal read returns zero.
- R6: Write data is right-aligned. A byte write stores bits 7:0 at the address. A halfword write stores bits 15:8 at the address and bits 7:0 at the address plus one. A word write stores bits 31:24 at the address through bits 7:0 at the address plus three.
- R7: A legal read returns the word at the address with bits 1:0 cleared. The lowest-addressed byte appears in bits 31:24. The data is registered: it appears after the sampling edge and holds until the next read is sampled, and writes do not change it.
- R8: An access is sampled on a rising edge where enable and ready are both high. Ready is low after that edge, stays low after the next edge, and is high again after the edge that follows.
- R9: An enable that is high while ready is low has no effect on storage.
- R10: A legal byte write to the console address (default 0xFFFFFFC0) does not change storage. In the cycle after the sampling edge, the console strobe is high for exactly one cycle and the console byte equals write data bits 7:0.
- R11: Storage holds WORDS words. The word index is the address divided by four, modulo WORDS, so higher address bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_lanes | input | 4 | Lane-select pattern giving the access size |
| acc_addr | input | ADDR_W | Byte address |
| acc_wdata | input | 32 | Right-aligned write data |
| acc_rdata | output | 32 | Registered big-endian read word |
| acc_rdy | output | 1 | Ready; low while an access is in progress |
| acc_err | output | 1 | Sticky illegal-access flag |
| con_valid | output | 1 | One-cycle console strobe |
| con_byte | output | 8 | Console byte |

## Verification
The bench builds the block with WORDS=16 and a 32-bit address, so all of storage is 64 bytes and a byte-array model can mirror it completely. This small configuration makes it practical to sweep all sixteen lane patterns against all four byte offsets, covering every legality outcome and every byte placement. Because the console address and address 0x44 both alias onto the first words of this small array, they can also show that the console write leaves storage alone and that the upper address bits wrap.

// File: rtl/lms_pkg.sv
package lms_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  typedef enum logic [1:0] {
    SZ_NONE,
    SZ_BYTE,
    SZ_HALF,
    SZ_WORD
  } lms_size_e;
endpackage

// File: rtl/lms_decode.sv
module lms_decode
  import lms_pkg::*;
(
  input  logic [LANES-1:0]  lanes,
  input  logic [1:0]        ofs,
  input  logic [WORD_W-1:0] wdata,
  output lms_size_e         size,
  output logic              legal,
  output logic [LANES-1:0]  bank_we,
  output logic [WORD_W-1:0] bank_wdata
);
  always_comb begin
    case (lanes)
      4'b1000, 4'b0100, 4'b0010, 4'b0001: size = SZ_BYTE;
      4'b1100, 4'b0011:                   size = SZ_HALF;
      4'b1111:                            size = SZ_WORD;
      default:                            size = SZ_NONE;
    endcase
  end

  always_comb begin
    legal = (size == SZ_BYTE) ||
            (size == SZ_HALF && !ofs[0]) ||
            (size == SZ_WORD && ofs == 2'b00);
  end

  // bank k holds the byte at offset k within a word
  always_comb begin
    bank_we    = '0;
    bank_wdata = '0;
    for (int k = 0; k < LANES; k++) begin
      unique case (size)
        SZ_BYTE: if (k == int'(ofs)) begin
          bank_we[k] = 1'b1;
          bank_wdata[k*BYTE_W +: BYTE_W] = wdata[7:0];
        end
        SZ_HALF: begin
          if (k == int'(ofs)) begin
            bank_we[k] = 1'b1;
            bank_wdata[k*BYTE_W +: BYTE_W] = wdata[15:8];
          end else if (k == int'(ofs) + 1) begin
            bank_we[k] = 1'b1;
            bank_wdata[k*BYTE_W +: BYTE_W] = wdata[7:0];
          end
        end
        SZ_WORD: begin
          bank_we[k] = 1'b1;
          bank_wdata[k*BYTE_W +: BYTE_W] = wdata[WORD_W-1-k*BYTE_W -: BYTE_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lms_bank.sv
module lms_bank #(
  parameter int WORDS = 256,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte
);
  logic [7:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wbyte;
    if (re) rbyte <= mem[idx];
  end
endmodule

// File: rtl/lms_handshake.sv
module lms_handshake (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic rdy,
  output logic samp
);
  logic hold_q;

  assign samp = en && rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy    <= 1'b1;
      hold_q <= 1'b0;
    end else if (samp) begin
      rdy    <= 1'b0;
      hold_q <= 1'b1;
    end else if (hold_q) begin
      hold_q <= 1'b0;
    end else begin
      rdy <= 1'b1;
    end
  end

  assert_rdy_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (en && rdy) |=> !rdy);
  assert_rdy_two_low_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy) |=> !rdy);
  assert_rdy_back_R8: assert property (@(posedge clk) disable iff (rst)
    (!rdy && $past(!rdy)) |=> rdy);
endmodule

// File: rtl/lms_console.sv
module lms_console (
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic [7:0] din,
  output logic       valid,
  output logic [7:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else     valid <= fire;
    if (fire) dout <= din;
  end

  assert_con_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
endmodule

// File: rtl/lane_mem_slave.sv
module lane_mem_slave
  import lms_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 256,
  parameter logic [ADDR_W-1:0] CON_ADDR = 'hFFFF_FFC0,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [LANES-1:0]  acc_lanes,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [WORD_W-1:0] acc_wdata,
  output logic [WORD_W-1:0] acc_rdata,
  output logic              acc_rdy,
  output logic              acc_err,
  output logic              con_valid,
  output logic [7:0]        con_byte
);
  lms_size_e         dec_size;
  logic              dec_legal;
  logic [LANES-1:0]  dec_we;
  logic [WORD_W-1:0] dec_wdata;
  logic              samp, is_con, wr_go, rd_go, con_go;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] rd_bytes, rd_word;
  logic              zero_q;

  lms_decode u_dec (
    .lanes(acc_lanes), .ofs(acc_addr[1:0]), .wdata(acc_wdata),
    .size(dec_size), .legal(dec_legal), .bank_we(dec_we), .bank_wdata(dec_wdata)
  );

  lms_handshake u_hs (.clk(clk), .rst(rst), .en(acc_en), .rdy(acc_rdy), .samp(samp));

  assign idx    = acc_addr[IDX_W+1:2];
  assign is_con = (acc_addr == CON_ADDR) && (dec_size == SZ_BYTE);
  assign wr_go  = samp && acc_we && dec_legal && !is_con;
  assign con_go = samp && acc_we && dec_legal && is_con;
  assign rd_go  = samp && !acc_we;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    lms_bank #(.WORDS(WORDS)) u_bank (
      .clk(clk), .we(wr_go && dec_we[g]), .re(rd_go), .idx(idx),
      .wbyte(dec_wdata[g*BYTE_W +: BYTE_W]), .rbyte(rd_bytes[g*BYTE_W +: BYTE_W])
    );
    assign rd_word[WORD_W-1-g*BYTE_W -: BYTE_W] = rd_bytes[g*BYTE_W +: BYTE_W];
  end

  lms_console u_con (
    .clk(clk), .rst(rst), .fire(con_go), .din(acc_wdata[7:0]),
    .valid(con_valid), .dout(con_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_q  <= 1'b1;
      acc_err <= 1'b0;
    end else begin
      if (rd_go) zero_q <= !dec_legal;
      if (samp && !dec_legal) acc_err <= 1'b1;
    end
  end

  assign acc_rdata = zero_q ? '0 : rd_word;

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    acc_err |=> acc_err);
  assert_bad_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (samp && !acc_we && !dec_legal) |=> (acc_rdata == '0 && acc_err));
  assert_legal_lanes_R2: assert property (@(posedge clk) disable iff (rst)
    (samp && dec_legal) |-> ($countones(acc_lanes) inside {1, 2, 4}));
  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> $stable(acc_rdata));
endmodule

// File: tb/lane_mem_slave_tb.sv
`timescale 1ns/1ps
module lane_mem_slave_tb;
  localparam int WORDS = 16;
  localparam int NB    = WORDS * 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0, acc_we = 1'b0;
  logic [3:0]  acc_lanes = '0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_rdy, acc_err, con_valid;
  logic [7:0]  con_byte;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [NB];

  always #10 clk = ~clk;

  lane_mem_slave #(.ADDR_W(32), .WORDS(WORDS)) u_dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we), .acc_lanes(acc_lanes),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_rdy(acc_rdy), .acc_err(acc_err), .con_valid(con_valid), .con_byte(con_byte)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal_f(input logic [3:0] s, input logic [1:0] o);
    case (s)
      4'b1000, 4'b0100, 4'b0010, 4'b0001: return 1'b1;
      4'b1100, 4'b0011: return !o[0];
      4'b1111: return o == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] mword(input logic [31:0] a);
    int b = int'(a[5:0]) & ~3;
    return {model[b], model[b+1], model[b+2], model[b+3]};
  endfunction

  task automatic mwrite(input logic [3:0] s, input logic [31:0] a, input logic [31:0] d);
    int b = int'(a[5:0]);
    if (!legal_f(s, a[1:0])) return;
    if (s == 4'b1111) begin
      model[b] = d[31:24]; model[b+1] = d[23:16]; model[b+2] = d[15:8]; model[b+3] = d[7:0];
    end else if (s == 4'b1100 || s == 4'b0011) begin
      model[b] = d[15:8]; model[b+1] = d[7:0];
    end else begin
      model[b] = d[7:0];
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic acc(input bit w, input logic [3:0] s, input logic [31:0] a, input logic [31:0] d);
    while (!acc_rdy) @(negedge clk);
    acc_en = 1'b1; acc_we = w; acc_lanes = s; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) model[i] = '0;
    do_reset();
    // R1 reset state
    chk(acc_rdy == 1'b1, "R1 rdy", acc_rdy, 1);
    chk(acc_err == 1'b0, "R1 err", acc_err, 0);
    chk(con_valid == 1'b0, "R1 con_valid", con_valid, 0);
    chk(acc_rdata == 32'h0, "R1 rdata", acc_rdata, 0);

    // R2 R3 R4 R5 R6: every lane pattern at every offset
    for (int s = 0; s < 16; s++) begin
      for (int o = 0; o < 4; o++) begin
        logic [3:0] sv = 4'(s);
        logic [1:0] ov = 2'(o);
        logic [31:0] a = 32'h20 + 32'(o);
        logic [31:0] d = {sv, ov, 2'b01, 8'hC5, sv, 4'h7, 6'h2A, ov};
        bit lg = legal_f(sv, ov);
        do_reset();
        acc(1'b1, sv, a, d);
        mwrite(sv, a, d);
        if (sv == 4'b1111)
          chk(acc_err == !lg, "R4 word legality", acc_err, !lg);
        else if (sv == 4'b1100 || sv == 4'b0011)
          chk(acc_err == !lg, "R3 half legality", acc_err, !lg);
        else if ($countones(sv) == 1)
          chk(acc_err == !lg, "R2 byte legality", acc_err, !lg);
        else
          chk(acc_err == 1'b1, "R5 bad pattern flagged", acc_err, 1);
        acc(1'b0, 4'b1111, 32'h20, 0);
        chk(acc_rdata == mword(32'h20), lg ? "R6 byte placement" : "R5 storage unchanged",
            acc_rdata, mword(32'h20));
        chk(acc_err == !lg, "R5 sticky err", acc_err, !lg);
      end
    end

    // R7 word order and read of any address within the word
    do_reset();
    acc(1'b1, 4'b1111, 32'h30, 32'h11223344); mwrite(4'b1111, 32'h30, 32'h11223344);
    acc(1'b0, 4'b0001, 32'h33, 0);
    chk(acc_rdata == 32'h11223344, "R7 whole word read", acc_rdata, 32'h11223344);
    acc(1'b1, 4'b0011, 32'h32, 32'h0000AABB); mwrite(4'b0011, 32'h32, 32'h0000AABB);
    chk(acc_rdata == 32'h11223344, "R7 rdata held over write", acc_rdata, 32'h11223344);
    acc(1'b0, 4'b1100, 32'h30, 0);
    chk(acc_rdata == 32'h1122AABB, "R6 halfword order", acc_rdata, 32'h1122AABB);

    // R5 illegal read returns zero
    acc(1'b0, 4'b1111, 32'h31, 0);
    chk(acc_rdata == 32'h0, "R5 bad read zero", acc_rdata, 0);
    chk(acc_err == 1'b1, "R5 err set", acc_err, 1);

    // R1 reset keeps storage
    do_reset();
    chk(acc_err == 1'b0, "R1 err cleared", acc_err, 0);
    acc(1'b0, 4'b1111, 32'h30, 0);
    chk(acc_rdata == 32'h1122AABB, "R1 storage kept", acc_rdata, 32'h1122AABB);

    // R8 R9 handshake timing, enable while busy ignored
    while (!acc_rdy) @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_lanes = 4'b1111; acc_addr = 32'h10; acc_wdata = 32'hA5A5_0001;
    mwrite(4'b1111, 32'h10, 32'hA5A5_0001);
    @(negedge clk);
    chk(acc_rdy == 1'b0, "R8 rdy low after sample", acc_rdy, 0);
    acc_wdata = 32'h5A5A_FFFF;
    @(negedge clk);
    chk(acc_rdy == 1'b0, "R8 rdy low second cycle", acc_rdy, 0);
    @(negedge clk);
    chk(acc_rdy == 1'b1, "R8 rdy back", acc_rdy, 1);
    acc_en = 1'b0;
    acc(1'b0, 4'b1111, 32'h10, 0);
    chk(acc_rdata == 32'hA5A5_0001, "R9 busy enable ignored", acc_rdata, 32'hA5A5_0001);

    // R10 console byte
    acc(1'b1, 4'b0001, 32'hFFFF_FFC0, 32'h1234_567E);
    chk(con_valid == 1'b1, "R10 strobe", con_valid, 1);
    chk(con_byte == 8'h7E, "R10 byte", con_byte, 8'h7E);
    @(negedge clk);
    chk(con_valid == 1'b0, "R10 one cycle", con_valid, 0);
    acc(1'b0, 4'b1111, 32'h0, 0);
    chk(acc_rdata == mword(32'h0), "R10 storage untouched", acc_rdata, mword(32'h0));

    // R11 aliasing of upper address bits
    acc(1'b1, 4'b1111, 32'h44, 32'hCAFE_F00D); mwrite(4'b1111, 32'h44, 32'hCAFE_F00D);
    acc(1'b0, 4'b1111, 32'h04, 0);
    chk(acc_rdata == 32'hCAFE_F00D, "R11 alias", acc_rdata, 32'hCAFE_F00D);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule